// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target side of a two-wire serial memory bus. It oversamples the clock and data lines on the system clock, finds bus start and stop conditions, shifts bytes in and out most significant bit first, and pulls the data line low to acknowledge. The engine never drives the data line high. It exposes only a drive-low enable, and the pad turns that into an open-drain output.

A transaction opens with a command byte. That byte carries the fixed prefix 1010, three bits that must equal the strap inputs, and a direction bit. A write command is followed by two word-address bytes, high byte first, and then by any number of data bytes. Each accepted data byte goes to a separate page-write unit. A read command returns bytes from a storage array, reached through a one-cycle synchronous read port, starting at the internal pointer. The engine keeps sending bytes for as long as the bus master acknowledges. Current-address, random (a write header, a repeated start, then a read header) and sequential reads are all supported.

The write hand-off is a valid/ready interface with one rule for back-pressure. The bus clock cannot be stretched, so the engine samples `wr_ready_i` in the cycle the eighth data bit arrives. If ready is high, it raises `wr_valid_o` for exactly one cycle and acknowledges the byte. If ready is low, the byte is dropped, it is not acknowledged and valid is never raised. While the page-write unit reports a write cycle in progress, command bytes go unacknowledged, so a master can poll for completion.

Top module: `tw_eeprom_target`

## Requirements
- R1: SDA falling while SCL is high (start) restarts command-byte reception from any state, even partway through a byte. SDA rising while SCL is high (stop) returns the engine to idle with the line released.
- R2: A command byte is acknowledged only when bits 7:4 are 1010 and bits 3:1 equal `strap_i`; bit 0 = 1 selects a read and 0 selects a write. After a mismatch the engine acknowledges nothing until the next start.
- R3: The engine acknowledges by asserting `sda_drive_low_o` for the ninth clock of a received byte. It asserts the output at no other time except to send 0 bits of read data, and it resets released.
- R4: While `wr_busy_i` is high, command bytes are not acknowledged and the pointer is unchanged.
- R5: After a write command, the two following bytes are acknowledged and load the pointer, the first byte into bits 15:8 and the second into bits 7:0.
- R6: A read returns the byte at the pointer, fetched through `rd_en_o`/`rd_addr_o` with `rd_data_i` valid one cycle later. The pointer then advances by one.
- R7: In a read, each master acknowledge (SDA low on the ninth clock) yields the next byte. A master no-acknowledge releases the line and ends the read.
- R8: The read pointer wraps from 0xFFFF to 0x0000.
- R9: An accepted data byte produces a single-cycle `wr_valid_o` carrying its address and data. The write address advances only in bits 6:0, wrapping inside its 128-byte page.
- R10: A data byte that completes while `wr_ready_i` is low is not acknowledged and raises no valid. The engine then ignores the bus until the next start.
- R11: `wr_commit_o` pulses for one cycle on a stop that follows at least one accepted data byte with no start in between. A start in between discards the commit.
- R12: After a write, a current-address read returns the byte at the last written address plus one, wrapped within the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 3 | Device select straps, compared with command bits 3:1 |
| sda_drive_low_o | output | 1 | 1 pulls the data line low; 0 releases it |
| rd_en_o | output | 1 | Array read strobe |
| rd_addr_o | output | AW | Array read address |
| rd_data_i | input | 8 | Array read data, valid the cycle after `rd_en_o` |
| wr_valid_o | output | 1 | Write byte valid, single cycle |
| wr_ready_i | input | 1 | Page-write unit can take a byte |
| wr_addr_o | output | AW | Address of the write byte |
| wr_data_o | output | 8 | Write byte |
| wr_commit_o | output | 1 | Stop pulse that ends a write sequence with data |
| wr_busy_i | input | 1 | Internal write cycle in progress |

## Verification
Bus conditions and bit-level events can fall in the same system cycle. The condition path has priority over byte completion, which decides whether a stop arriving partway through a byte, or a repeated start after an accepted data byte, is honoured. The bench provokes the first case by sending four bits of a command byte and then a stop. It judges the result by a clean acknowledge and the correct data on the next current-address read. It provokes the second case with a repeated start right after a data byte is acknowledged. It judges that case by the commit pulse count staying unchanged while the following read still sees the advanced pointer.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } eng_state_t;

  typedef enum logic [1:0] {
    K_HDR,
    K_AH,
    K_AL,
    K_WD
  } rx_kind_t;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int         STRAP_W    = 3;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '1;
    end else begin
      pipe[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // conditions only count while the clock line stays high across the edge
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
  parameter int AW = 16,
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_lin_i,
  input  logic          inc_page_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ptr_o <= '0;
    else if (load_i)     ptr_o <= load_val_i;
    else if (inc_lin_i)  ptr_o <= ptr_o + 1'b1;
    else if (inc_page_i) ptr_o <= {ptr_o[AW-1:PW], ptr_o[PW-1:0] + 1'b1};
  end

  assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_page_i && !load_i && !inc_lin_i) |=> ptr_o[AW-1:PW] == $past(ptr_o[AW-1:PW]));

  assert_lin_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_lin_i && !load_i) |=> ptr_o == AW'($past(ptr_o) + 1'b1));
endmodule

// File: rtl/tw_eeprom_target.sv
module tw_eeprom_target
  import tw_pkg::*;
#(
  parameter int AW          = 16,
  parameter int PW          = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_drive_low_o,
  output logic               rd_en_o,
  output logic [AW-1:0]      rd_addr_o,
  input  logic [7:0]         rd_data_i,
  output logic               wr_valid_o,
  input  logic               wr_ready_i,
  output logic [AW-1:0]      wr_addr_o,
  output logic [7:0]         wr_data_o,
  output logic               wr_commit_o,
  input  logic               wr_busy_i
);
  localparam int HW = AW - 8;

  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_c, stop_c;

  tw_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  tw_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  eng_state_t    state;
  rx_kind_t      kind;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, txbuf;
  logic          ack_pend, hdr_read, more, wrote, rd_pend;
  logic [HW-1:0] addr_hi;
  logic [AW-1:0] ptr;

  logic [7:0] byte_in;
  logic       rx_done, hdr_match, hdr_ok, rd_fetch, wd_take, al_load;

  assign byte_in   = {shreg[6:0], sda_s};
  assign rx_done   = (state == ST_RX) && scl_rise && (bitcnt == 4'd7) && !start_c && !stop_c;
  assign hdr_match = (byte_in[7:4] == DEV_PREFIX) && (byte_in[3:1] == strap_i);
  assign hdr_ok    = rx_done && (kind == K_HDR) && hdr_match && !wr_busy_i;
  assign rd_fetch  = (hdr_ok && byte_in[0]) ||
                     ((state == ST_TX_ACK) && scl_rise && !sda_s && !start_c && !stop_c);
  assign wd_take   = rx_done && (kind == K_WD) && wr_ready_i;
  assign al_load   = rx_done && (kind == K_AL);

  tw_addr_ptr #(.AW(AW), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load_i(al_load), .load_val_i({addr_hi, byte_in}),
    .inc_lin_i(rd_fetch), .inc_page_i(wd_take),
    .ptr_o(ptr)
  );

  // read port: strobe, then data one cycle later, captured into the send buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
      rd_pend   <= 1'b0;
      txbuf     <= '0;
    end else begin
      rd_en_o <= rd_fetch;
      rd_pend <= rd_en_o;
      if (rd_fetch) rd_addr_o <= ptr;
      if (rd_pend)  txbuf     <= rd_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= ST_IDLE;
      kind            <= K_HDR;
      bitcnt          <= '0;
      shreg           <= '0;
      ack_pend        <= 1'b0;
      hdr_read        <= 1'b0;
      more            <= 1'b0;
      wrote           <= 1'b0;
      addr_hi         <= '0;
      sda_drive_low_o <= 1'b0;
      wr_valid_o      <= 1'b0;
      wr_addr_o       <= '0;
      wr_data_o       <= '0;
      wr_commit_o     <= 1'b0;
    end else begin
      wr_valid_o  <= 1'b0;
      wr_commit_o <= 1'b0;
      if (start_c) begin
        state           <= ST_RX;
        kind            <= K_HDR;
        bitcnt          <= '0;
        ack_pend        <= 1'b0;
        wrote           <= 1'b0;
        sda_drive_low_o <= 1'b0;
      end else if (stop_c) begin
        state           <= ST_IDLE;
        sda_drive_low_o <= 1'b0;
        wr_commit_o     <= wrote;
        wrote           <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= byte_in;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == 4'd7) begin
                unique case (kind)
                  K_HDR: begin
                    ack_pend <= hdr_ok;
                    hdr_read <= byte_in[0];
                  end
                  K_AH: begin
                    addr_hi  <= byte_in[HW-1:0];
                    ack_pend <= 1'b1;
                  end
                  K_AL: ack_pend <= 1'b1;
                  K_WD: begin
                    ack_pend <= wr_ready_i;
                    if (wr_ready_i) begin
                      wr_valid_o <= 1'b1;
                      wr_addr_o  <= ptr;
                      wr_data_o  <= byte_in;
                      wrote      <= 1'b1;
                    end
                  end
                  default: ;
                endcase
              end
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (ack_pend) begin
                sda_drive_low_o <= 1'b1;
                state           <= ST_RX_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bitcnt          <= '0;
              sda_drive_low_o <= 1'b0;
              if (kind == K_HDR && hdr_read) begin
                state           <= ST_TX;
                sda_drive_low_o <= ~txbuf[7];
              end else begin
                state <= ST_RX;
                unique case (kind)
                  K_HDR:   kind <= K_AH;
                  K_AH:    kind <= K_AL;
                  default: kind <= K_WD;
                endcase
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_drive_low_o <= 1'b0;
                state           <= ST_TX_ACK;
              end else begin
                sda_drive_low_o <= ~txbuf[3'(7 - bitcnt)];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              more <= !sda_s;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (more) begin
                state           <= ST_TX;
                sda_drive_low_o <= ~txbuf[7];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state == ST_RX && kind == K_HDR && bitcnt == 4'd0));

  assert_stop_idles_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && !start_c) |=> (state == ST_IDLE && !sda_drive_low_o));

  assert_drive_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low_o |-> (state == ST_RX_ACK || state == ST_TX));

  assert_busy_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && kind == K_HDR && wr_busy_i) |=> !ack_pend);

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);

  assert_valid_after_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> $past(wr_ready_i));

  assert_commit_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |=> !wr_commit_o);
endmodule

// File: tb/tb_tw_eeprom_target.sv
module tb_tw_eeprom_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 3;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] HW_WR = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] HW_RD = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic drv;
  logic sda_bus;
  logic rd_en, wr_valid, wr_commit;
  logic [15:0] rd_addr, wr_addr;
  logic [7:0]  rd_data, wr_data;
  logic wr_ready = 1'b1, wr_busy = 1'b0;

  int errors = 0, checks = 0;
  int wcnt = 0, ccnt = 0;
  logic [15:0] log_a [0:15];
  logic [7:0]  log_d [0:15];
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~drv;

  tw_eeprom_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(STRAP),
    .sda_drive_low_o(drv), .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_commit_o(wr_commit), .wr_busy_i(wr_busy)
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ 8'(a[15:8] * 8'd3) ^ 8'h3C;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mem_f(rd_addr);

  always @(negedge clk) begin
    if (wr_valid && wcnt < 16) begin
      log_a[wcnt] = wr_addr;
      log_d[wcnt] = wr_data;
    end
    if (wr_valid) wcnt++;
    if (wr_commit) ccnt++;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_io(input logic v, output logic s);
    wq(); sda_m = v; wq(); scl_m = 1'b1; wq(); s = sda_bus; wq(); scl_m = 1'b0;
  endtask

  task automatic do_start();
    wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
  endtask

  task automatic do_stop();
    wq(); sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      b[i] = s;
    end
    bit_io(!mack, s);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    logic [15:0] mp;
    int wbase, cbase;
    mp = 16'h0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R3: reset state released and idle
    chk(drv == 1'b0 && wr_valid == 1'b0 && rd_en == 1'b0 && wr_commit == 1'b0,
        "R3 reset", int'({drv, wr_valid, rd_en, wr_commit}), 0);

    // R2/R6: sweep all command bytes
    for (int h = 0; h < 256; h++) begin
      logic exp_ack;
      exp_ack = (h[7:1] == {4'b1010, STRAP});
      do_start();
      send_byte(8'(h), ack);
      chk(ack == exp_ack, "R2 header", int'(ack), int'(exp_ack));
      if (ack && h[0]) begin
        recv_byte(1'b0, b);
        chk(b == mem_f(mp), "R6 current read", int'(b), int'(mem_f(mp)));
        mp = mp + 1'b1;
      end
      do_stop();
      chk(drv == 1'b0, "R1 stop releases", int'(drv), 0);
    end

    // R2: after a mismatch, a matching byte without start is ignored
    do_start();
    send_byte(8'hA0, ack);
    send_byte(HW_WR, ack);
    chk(!ack, "R2 ignored after mismatch", int'(ack), 0);
    do_stop();

    // R5/R7/R8: random read across the top of the array
    do_start();
    send_byte(HW_WR, ack); chk(ack, "R5 write header", int'(ack), 1);
    send_byte(8'hFF, ack); chk(ack, "R5 high address", int'(ack), 1);
    send_byte(8'hFD, ack); chk(ack, "R5 low address", int'(ack), 1);
    do_start();
    send_byte(HW_RD, ack); chk(ack, "R6 read header", int'(ack), 1);
    mp = 16'hFFFD;
    for (int k = 0; k < 5; k++) begin
      recv_byte(k < 4, b);
      chk(b == mem_f(mp), "R8 sequential wrap", int'(b), int'(mem_f(mp)));
      mp = mp + 1'b1;
    end
    do_stop();
    chk(drv == 1'b0, "R7 nack ends read", int'(drv), 0);

    do_start();
    send_byte(HW_RD, ack);
    recv_byte(1'b0, b);
    chk(b == mem_f(16'h0002), "R6 current after wrap", int'(b), int'(mem_f(16'h0002)));
    do_stop();

    // R9/R11/R12: page write wrapping inside its page
    wbase = wcnt; cbase = ccnt;
    do_start();
    send_byte(HW_WR, ack);
    send_byte(8'h12, ack);
    send_byte(8'h7E, ack);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'(8'h11 * (k + 1)), ack);
      chk(ack, "R9 data ack", int'(ack), 1);
    end
    do_stop();
    repeat (4) @(negedge clk);
    chk(wcnt - wbase == 4, "R9 valid count", wcnt - wbase, 4);
    for (int k = 0; k < 4; k++) begin
      logic [15:0] ea;
      ea = {9'h024, 7'(7'h7E + k)};
      chk(log_a[wbase + k] == ea, "R9 page address", int'(log_a[wbase + k]), int'(ea));
      chk(log_d[wbase + k] == 8'(8'h11 * (k + 1)), "R9 data", int'(log_d[wbase + k]),
          int'(8'(8'h11 * (k + 1))));
    end
    chk(ccnt - cbase == 1, "R11 commit", ccnt - cbase, 1);
    do_start();
    send_byte(HW_RD, ack);
    recv_byte(1'b0, b);
    chk(b == mem_f(16'h1202), "R12 pointer after write", int'(b), int'(mem_f(16'h1202)));
    do_stop();

    // R10: not ready -> nack, no valid, idle until start
    wbase = wcnt; cbase = ccnt;
    do_start();
    send_byte(HW_WR, ack);
    send_byte(8'h00, ack);
    send_byte(8'h10, ack);
    wr_ready = 1'b0;
    send_byte(8'h55, ack);
    chk(!ack, "R10 nack when not ready", int'(ack), 0);
    wr_ready = 1'b1;
    send_byte(8'h66, ack);
    chk(!ack, "R10 idle after drop", int'(ack), 0);
    do_stop();
    repeat (4) @(negedge clk);
    chk(wcnt == wbase, "R10 no valid", wcnt - wbase, 0);
    chk(ccnt == cbase, "R11 no commit without data", ccnt - cbase, 0);

    // R4: busy suppresses command acknowledge
    wr_busy = 1'b1;
    do_start(); send_byte(HW_RD, ack); do_stop();
    chk(!ack, "R4 busy read header", int'(ack), 0);
    do_start(); send_byte(HW_WR, ack); do_stop();
    chk(!ack, "R4 busy write header", int'(ack), 0);
    wr_busy = 1'b0;
    do_start(); send_byte(HW_RD, ack);
    chk(ack, "R4 ack after busy", int'(ack), 1);
    recv_byte(1'b0, b);
    chk(b == mem_f(16'h0010), "R4 pointer unchanged", int'(b), int'(mem_f(16'h0010)));
    do_stop();

    // R1: stop partway through a command byte
    do_start();
    for (int i = 7; i >= 4; i--) begin
      logic s;
      bit_io(HW_RD[i], s);
    end
    do_stop();
    do_start(); send_byte(HW_RD, ack);
    chk(ack, "R1 ack after aborted byte", int'(ack), 1);
    recv_byte(1'b0, b);
    chk(b == mem_f(16'h0011), "R1 read after abort", int'(b), int'(mem_f(16'h0011)));
    do_stop();

    // R11: repeated start after data discards the commit
    cbase = ccnt;
    do_start();
    send_byte(HW_WR, ack);
    send_byte(8'h20, ack);
    send_byte(8'h00, ack);
    send_byte(8'h77, ack);
    chk(ack, "R9 data before restart", int'(ack), 1);
    do_start();
    send_byte(HW_RD, ack);
    recv_byte(1'b0, b);
    chk(b == mem_f(16'h2001), "R12 read after restart", int'(b), int'(mem_f(16'h2001)));
    do_stop();
    repeat (4) @(negedge clk);
    chk(ccnt == cbase, "R11 restart discards commit", ccnt - cbase, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule